// File: doc/BRIEF.md
# Indirect PLL Configuration Register Port

This block sits on the host side of a clock generator. It holds a small bank of byte-wide PLL configuration registers that the host reaches through a narrow window. One port takes an address byte that selects a register and carries a write-enable flag. A second port is the data byte for the selected register. A third port takes a clock-control byte that picks which of four pixel clocks is active and can fire a strobe.

To write a register, software sends the address byte with write-enable set, then the data byte, then the same address byte with write-enable clear. To read a register, software sends the address byte with write-enable clear and then reads the data port.

Three registers have fixed meanings. The post-divider register packs a 2-bit post-divider code for each clock. The extended-control register carries one extended post-divider bit per clock in its upper nibble, and its lower nibble holds shared settings. Each clock has its own feedback divider register. The block decodes the settings of the active clock and drives them onto outputs for the downstream synthesizer logic.

Top module: `pll_cfg_port`

## Requirements
- R1: A synchronous active-low reset clears every bank register, the register index, the write-enable flag, the active clock select, the strobe and the read data to zero.
- R2: A write to the address port (port code 0) loads the register index from bits [5:2] and the write-enable flag from bit 1. A read of the address port returns the index in bits [5:2] and the flag in bit 1, with bits 7:6 and 0 reading as zero.
- R3: A write to the data port (port code 1) while the write-enable flag is set stores the whole byte in the selected register.
- R4: A write to the data port while the write-enable flag is clear changes no register and no decoded output.
- R5: A read of the data port returns the selected register on bus_rdata after the clock edge of the read, whatever the state of the write-enable flag.
- R6: A write to the clock-control port (port code 2) sets the active clock to bits [1:0]. If bit 7 is also set, clk_strobe is high for exactly the one cycle after that edge. A read of this port returns the active clock in bits [1:0] and zero in the other bits.
- R7: act_post_code equals bits [2n+1:2n] of register 0 (the post-divider register), where n is the active clock.
- R8: act_post_ext equals bit 4+n of register 1 (the extended-control register).
- R9: act_fb_div equals register 2+n (the feedback divider of clock n).
- R10: Writes to port code 3 have no effect, and reads of port code 3 return zero.
- R11: bus_rdata holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe for the port named by bus_sel |
| bus_rd | input | 1 | Host read strobe for the port named by bus_sel |
| bus_sel | input | 2 | Port code: 0 address, 1 data, 2 clock control, 3 unused |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Registered read byte |
| act_clk | output | 2 | Active pixel clock index |
| clk_strobe | output | 1 | One-cycle pulse after a clock-control write with bit 7 set |
| act_post_code | output | 2 | Post-divider code of the active clock |
| act_post_ext | output | 1 | Extended post-divider bit of the active clock |
| act_fb_div | output | 8 | Feedback divider of the active clock |

## Verification
The assertions check on every cycle the properties that relate a cycle to the one after it. These are: a data write with the flag clear leaves the decoded outputs unchanged, and a data write with the flag set to the active clock's feedback register shows up on act_fb_div. The strobe rises only after a clock-control write with bit 7 set, the clock select follows the written byte, and read data holds when there is no read. Only the bench scenarios can show the field packing of each clock, the readback layout of the address and clock-control ports, the full three-step write and two-step read sequences across all registers, and the reset values. The bench compares these against a model of the bank under random traffic.

// File: rtl/pll_port_pkg.sv
// Shared definitions for the indirect PLL configuration port.
// Assumes a byte-wide host bus with a 2-bit port code.
package pll_port_pkg;
    typedef enum logic [1:0] {
        PORT_ADDR = 2'd0,
        PORT_DATA = 2'd1,
        PORT_CLK  = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    localparam int IDX_LSB    = 2;  // register index position in address byte
    localparam int WE_BIT     = 1;  // write-enable flag in address byte
    localparam int STROBE_BIT = 7;  // strobe request in clock-control byte
    localparam int POST_W     = 2;  // post-divider code width per clock
    localparam int EXT_LSB    = 4;  // first per-clock extended bit
endpackage

// File: rtl/pll_addr_ctl.sv
// Address and clock-control latch: holds the selected register index,
// the write-enable flag, the active clock select and the strobe pulse.
// Assumes at most one host write per cycle.
module pll_addr_ctl
    import pll_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx_q,
    output logic              we_q,
    output logic [SEL_W-1:0]  act_sel_q,
    output logic              strobe_q,
    output logic [DATA_W-1:0] addr_rb,
    output logic [DATA_W-1:0] clk_rb
);
    logic unused_wdata;

    // Address byte capture: index field and write-enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            we_q  <= 1'b0;
        end else if (wr && port_e'(sel) == PORT_ADDR) begin
            idx_q <= wdata[IDX_LSB +: IDX_W];
            we_q  <= wdata[WE_BIT];
        end
    end

    // Clock-control capture: active clock and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel_q <= '0;
            strobe_q  <= 1'b0;
        end else begin
            strobe_q <= wr && port_e'(sel) == PORT_CLK && wdata[STROBE_BIT];
            if (wr && port_e'(sel) == PORT_CLK)
                act_sel_q <= wdata[SEL_W-1:0];
        end
    end

    // Readback images of the two control ports.
    always_comb begin
        addr_rb = '0;
        addr_rb[IDX_LSB +: IDX_W] = idx_q;
        addr_rb[WE_BIT] = we_q;
        clk_rb = '0;
        clk_rb[SEL_W-1:0] = act_sel_q;
    end

    assign unused_wdata = ^wdata;
endmodule

// File: rtl/pll_reg_bank.sv
// Register bank with the registered read path. A data-port write updates
// the selected register only while the write-enable flag is set.
// Assumes NUM_REG covers the fixed registers used by the decoder.
module pll_reg_bank
    import pll_port_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 4,
    parameter int NUM_CLK = 4,
    parameter int POST_REG = 0,
    parameter int EXT_REG  = 1,
    parameter int FB_BASE  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic                           rd,
    input  logic [1:0]                     sel,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [IDX_W-1:0]               idx,
    input  logic                           we,
    input  logic [DATA_W-1:0]              addr_rb,
    input  logic [DATA_W-1:0]              clk_rb,
    output logic [DATA_W-1:0]              rdata_q,
    output logic [DATA_W-1:0]              post_reg,
    output logic [DATA_W-1:0]              ext_reg,
    output logic [NUM_CLK-1:0][DATA_W-1:0] fb_regs
);
    localparam int NUM_REG = 1 << IDX_W;

    logic [DATA_W-1:0] bank [NUM_REG];
    logic              wr_hit;

    assign wr_hit = wr && we && port_e'(sel) == PORT_DATA;

    // Register storage, written through the data port.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REG; i++) begin
            if (!rst_n)
                bank[i] <= '0;
            else if (wr_hit && idx == IDX_W'(i))
                bank[i] <= wdata;
        end
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd) begin
            case (port_e'(sel))
                PORT_ADDR: rdata_q <= addr_rb;
                PORT_DATA: rdata_q <= bank[idx];
                PORT_CLK:  rdata_q <= clk_rb;
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign post_reg = bank[POST_REG];
    assign ext_reg  = bank[EXT_REG];

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_fb
        assign fb_regs[g] = bank[FB_BASE + g];
    end
endmodule

// File: rtl/pll_clk_decode.sv
// Picks the active clock's packed fields out of the shared registers.
// Assumes NUM_CLK is a power of two and fits the packed layouts.
module pll_clk_decode
    import pll_port_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_CLK = 4,
    parameter int SEL_W   = 2
) (
    input  logic [SEL_W-1:0]               act_sel,
    input  logic [DATA_W-1:0]              post_reg,
    input  logic [DATA_W-1:0]              ext_reg,
    input  logic [NUM_CLK-1:0][DATA_W-1:0] fb_regs,
    output logic [POST_W-1:0]              post_code,
    output logic                           post_ext,
    output logic [DATA_W-1:0]              fb_div
);
    logic [POST_W-1:0] post_f [NUM_CLK];
    logic              ext_f  [NUM_CLK];
    logic              unused_ext;

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_field
        assign post_f[g] = post_reg[POST_W*g +: POST_W];
        assign ext_f[g]  = ext_reg[EXT_LSB + g];
    end

    // Field selection by the active clock.
    always_comb begin
        post_code = post_f[act_sel];
        post_ext  = ext_f[act_sel];
        fb_div    = fb_regs[act_sel];
    end

    assign unused_ext = ^{ext_reg, post_reg};
endmodule

// File: rtl/pll_cfg_port.sv
// Top of the indirect PLL configuration port: address latch, bank and
// active-clock decoder. Assumes a synchronous active-low reset.
module pll_cfg_port
    import pll_port_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 4,
    parameter int NUM_CLK  = 4,
    parameter int POST_REG = 0,
    parameter int EXT_REG  = 1,
    parameter int FB_BASE  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_sel,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [1:0]  act_clk,
    output logic        clk_strobe,
    output logic [1:0]  act_post_code,
    output logic        act_post_ext,
    output logic [7:0]  act_fb_div
);
    localparam int SEL_W = $clog2(NUM_CLK);

    logic [IDX_W-1:0]               idx_q;
    logic                           we_q;
    logic [DATA_W-1:0]              addr_rb, clk_rb;
    logic [DATA_W-1:0]              post_reg, ext_reg;
    logic [NUM_CLK-1:0][DATA_W-1:0] fb_regs;

    pll_addr_ctl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(bus_sel), .wdata(bus_wdata),
        .idx_q(idx_q), .we_q(we_q), .act_sel_q(act_clk), .strobe_q(clk_strobe),
        .addr_rb(addr_rb), .clk_rb(clk_rb)
    );

    pll_reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_CLK(NUM_CLK),
                   .POST_REG(POST_REG), .EXT_REG(EXT_REG), .FB_BASE(FB_BASE)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .sel(bus_sel),
        .wdata(bus_wdata), .idx(idx_q), .we(we_q), .addr_rb(addr_rb),
        .clk_rb(clk_rb), .rdata_q(bus_rdata), .post_reg(post_reg),
        .ext_reg(ext_reg), .fb_regs(fb_regs)
    );

    pll_clk_decode #(.DATA_W(DATA_W), .NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) u_dec (
        .act_sel(act_clk), .post_reg(post_reg), .ext_reg(ext_reg),
        .fb_regs(fb_regs), .post_code(act_post_code), .post_ext(act_post_ext),
        .fb_div(act_fb_div)
    );
endmodule

// File: rtl/pll_cfg_port_chk.sv
// Cycle-level checks for pll_cfg_port, attached by bind.
module pll_cfg_port_chk #(
    parameter int IDX_W   = 4,
    parameter int FB_BASE = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_sel,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic [1:0]       act_clk,
    input logic             clk_strobe,
    input logic [1:0]       act_post_code,
    input logic             act_post_ext,
    input logic [7:0]       act_fb_div,
    input logic [IDX_W-1:0] idx_q,
    input logic             we_q
);
    logic fb_hit;
    assign fb_hit = (32'(idx_q) == FB_BASE + 32'(act_clk));

    // R4: a data write with the flag clear leaves the decoded outputs alone
    p_ignored_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd1 && !we_q)
        |=> ($stable(act_fb_div) && $stable(act_post_code) && $stable(act_post_ext)));

    // R9: an enabled write to the active clock's feedback register shows up
    p_fb_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd1 && we_q && fb_hit) |=> act_fb_div == $past(bus_wdata));

    // R6: strobe request produces the pulse
    p_strobe_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2 && bus_wdata[7]) |=> clk_strobe);

    // R6: strobe only after a strobe request
    p_strobe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_strobe |-> $past(bus_wr && bus_sel == 2'd2 && bus_wdata[7]));

    // R6: clock select follows the clock-control write
    p_clk_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2) |=> act_clk == $past(bus_wdata[1:0]));

    // R5: reading the active feedback register returns the decoded value
    p_read_fb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_sel == 2'd1 && fb_hit) |=> bus_rdata == act_fb_div);

    // R11: read data holds without a read
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind pll_cfg_port pll_cfg_port_chk #(.IDX_W(IDX_W), .FB_BASE(FB_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .act_clk(act_clk), .clk_strobe(clk_strobe), .act_post_code(act_post_code),
    .act_post_ext(act_post_ext), .act_fb_div(act_fb_div),
    .idx_q(idx_q), .we_q(we_q)
);

// File: tb/sim_pll_cfg_port.sv
module sim_pll_cfg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] act_clk, act_post_code;
    logic       clk_strobe, act_post_ext;
    logic [7:0] act_fb_div;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    logic [7:0] m_bank [16];
    logic [3:0] m_idx;
    logic       m_we;
    logic [1:0] m_sel;
    logic [7:0] m_rdata;

    pll_cfg_port u0 (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] e_post(input logic [1:0] n);
        return m_bank[0][2*n +: 2];
    endfunction
    function automatic logic e_ext(input logic [1:0] n);
        return m_bank[1][4+n];
    endfunction
    function automatic logic [7:0] e_fb(input logic [1:0] n);
        return m_bank[2+n];
    endfunction
    function automatic logic [7:0] e_read(input logic [1:0] s);
        case (s)
            2'd0: return {2'b00, m_idx, m_we, 1'b0};
            2'd1: return m_bank[m_idx];
            2'd2: return {6'd0, m_sel};
            default: return 8'd0;
        endcase
    endfunction

    task automatic check_dec();
        chk("R6 act_clk", act_clk, m_sel);
        chk("R7 post code", act_post_code, e_post(m_sel));
        chk("R8 ext bit", act_post_ext, e_ext(m_sel));
        chk("R9 fb div", act_fb_div, e_fb(m_sel));
    endtask

    task automatic do_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (s)
            2'd0: begin m_idx = d[5:2]; m_we = d[1]; end
            2'd1: if (m_we) m_bank[m_idx] = d;
            2'd2: m_sel = d[1:0];
            default: ;
        endcase
        chk("R6 strobe", clk_strobe, (s == 2'd2) && d[7]);
        check_dec();
        chk("R11 rdata hold", bus_rdata, m_rdata);
    endtask

    task automatic do_read(input logic [1:0] s, input string tag);
        logic [7:0] e;
        e = e_read(s);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = s;
        @(negedge clk);
        bus_rd = 1'b0;
        m_rdata = e;
        chk(tag, bus_rdata, e);
        chk("R6 strobe low", clk_strobe, 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1ce5_0a7d));
        for (int i = 0; i < 16; i++) m_bank[i] = 8'd0;
        m_idx = 0; m_we = 0; m_sel = 0; m_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 strobe", clk_strobe, 0);
        check_dec();
        do_read(2'd1, "R1 reg0 after reset");
        do_read(2'd0, "R1 addr after reset");

        // R3/R9: three-step write to clock 0 feedback divider
        do_write(2'd0, 8'h0A);
        do_write(2'd1, 8'h80);
        do_write(2'd0, 8'h08);
        // R4: data write with flag clear ignored
        do_write(2'd1, 8'hFF);
        chk("R4 fb unchanged", act_fb_div, 8'h80);
        do_read(2'd1, "R5 read fb0");
        do_read(2'd0, "R2 addr readback");

        // Load post, ext and all feedback registers
        do_write(2'd0, 8'h02); do_write(2'd1, 8'hE4);
        do_write(2'd0, 8'h06); do_write(2'd1, 8'hAF);
        for (int n = 0; n < 4; n++) begin
            do_write(2'd0, 8'((2+n) << 2) | 8'h02);
            do_write(2'd1, 8'h80 + 8'(n * 8'h11));
        end
        do_write(2'd0, 8'h00);
        // R7/R8/R9 per clock, strobe on clock 2
        for (int n = 0; n < 4; n++) begin
            do_write(2'd2, 8'(n) | (n == 2 ? 8'h80 : 8'h00));
            chk("R7 directed post", act_post_code, n);
            do_read(2'd2, "R6 clk readback");
        end
        // R10: unused port code
        do_write(2'd3, 8'hFF);
        do_read(2'd3, "R10 unused read");
        // R11: hold across idle cycles
        repeat (5) @(negedge clk);
        chk("R11 idle hold", bus_rdata, m_rdata);

        // Random traffic
        for (int it = 0; it < 600; it++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 5);
            d = 8'($urandom);
            case (op)
                0: do_write(2'd0, d);
                1: do_write(2'd1, d);
                2: do_write(2'd2, d);
                3: do_write(2'd3, d);
                4: do_read(2'd1, "R5 random data read");
                default: do_read(2'($urandom_range(0, 3)), "R2 random port read");
            endcase
        end

        // R1: reset in the middle clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) m_bank[i] = 8'd0;
        m_idx = 0; m_we = 0; m_sel = 0; m_rdata = 0;
        chk("R1 rdata after reset", bus_rdata, 0);
        check_dec();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule